// File: doc/BRIEF.md
# Multi-Level Trigger Condition Sequencer

This block is the trigger engine of an on-chip logic analyzer. It watches a set of probe signals plus one external trigger input. Up to `MAX_LEVELS` trigger levels are stored. Each level holds a 3-bit condition for every probe and for the external input. A condition tests the current sample, or the current sample against the one taken a clock earlier.

Once armed, the engine tests one level per cycle, starting at level one. When every condition of the current level holds in the same cycle, it moves on to the next level. When the last configured level matches, it emits a one-cycle pulse towards a capture buffer. It also raises a trigger output that stays high until the next arm or disarm. That output can drive the external trigger input of another instance, so analyzers can be chained.

Configuration is written through a small write port while the engine is idle.

Top module: `trigSeq`

## Requirements
- R1: After reset, `trigPulse` and `trigOut` are low, the engine is idle, the level count is 1 and every stored condition is don't care.
- R2: Condition codes are 0 don't care, 1 low, 2 high, 3 rising edge, 4 falling edge and 5 either edge; codes 6 and 7 behave as don't care. Slot indices 0 to NUM_SIG-1 select `probe` bits and slot NUM_SIG selects `extTrigIn`.
- R3: An edge is found by comparing a signal with its value one clock earlier. In the first cycle after an arm, no edge condition is true.
- R4: A level matches only when all of its slot conditions hold in the same cycle. The engine then tests the next level, starting in the following cycle.
- R5: The level count written through `depthWe` is accepted only in the range 1 to MAX_LEVELS; other values are ignored. A trigger needs levels 1 to count matched in order.
- R6: `trigPulse` is high for exactly the one cycle after the cycle in which the last level matched. `trigOut` rises together with it and stays high until an arm or a disarm.
- R7: After a trigger, further matches produce no pulse until the next arm. An arm from any state restarts the sequence at level one.
- R8: Condition and level-count writes are accepted only while the engine is idle. Writes with a level index of MAX_LEVELS or above, or a slot index above NUM_SIG, are ignored.
- R9: `disarm` returns the engine to idle from any state and clears `trigOut`. It wins over `arm` in the same cycle.
- R10: The external input takes part as an ordinary slot. A rising condition on it lets a second instance trigger one cycle after the first instance's pulse, when fed from the first instance's `trigOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Acquisition clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| probe | input | NUM_SIG | Probe signals under test |
| extTrigIn | input | 1 | External trigger source, extra slot |
| cfgWe | input | 1 | Condition write strobe |
| cfgLevel | input | LVL_W | Level index for the condition write |
| cfgSlot | input | SLOT_W | Slot index for the condition write |
| cfgCode | input | 3 | Condition code to store |
| depthWe | input | 1 | Level-count write strobe |
| depthVal | input | DEPTH_W | Number of active levels |
| arm | input | 1 | Start or restart the sequence at level one |
| disarm | input | 1 | Return to idle |
| trigPulse | output | 1 | One-cycle trigger pulse to the capture buffer |
| trigOut | output | 1 | Trigger output, high from the trigger until arm or disarm |

## Verification
The bench builds the block with four probes and ten levels. Four probes let random probe patterns satisfy whole levels often, so deep sequences do complete. Ten levels make the full-depth limit reachable, and a count of eleven can be tried and must be rejected. A second instance is fed from the first one's trigger output through its external slot, which exercises chaining.

// File: rtl/trigSeqPkg.sv
package trigSeqPkg;

  localparam logic [2:0] CodeAny    = 3'd0;
  localparam logic [2:0] CodeLow    = 3'd1;
  localparam logic [2:0] CodeHigh   = 3'd2;
  localparam logic [2:0] CodeRise   = 3'd3;
  localparam logic [2:0] CodeFall   = 3'd4;
  localparam logic [2:0] CodeToggle = 3'd5;

  typedef enum logic [1:0] {
    StIdle = 2'd0,
    StHunt = 2'd1,
    StDone = 2'd2
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic codeWrite;
    logic depthWrite;
    logic restart;
  } dpStrobeT;

  function automatic logic condOk(input logic [2:0] code, input logic cur,
                                  input logic prev, input logic histValid);
    logic ok;
    case (code)
      CodeLow:    ok = ~cur;
      CodeHigh:   ok = cur;
      CodeRise:   ok = histValid & cur & ~prev;
      CodeFall:   ok = histValid & ~cur & prev;
      CodeToggle: ok = histValid & (cur ^ prev);
      default:    ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/trigSeqData.sv
module trigSeqData
  import trigSeqPkg::*;
#(
  parameter int NUM_SIG    = 8,
  parameter int MAX_LEVELS = 10,
  localparam int LVL_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1,
  localparam int SLOTS     = NUM_SIG + 1,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int DEPTH_W   = $clog2(MAX_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SIG-1:0] probe,
  input  logic               extTrigIn,
  input  dpStrobeT           strobe,
  input  logic [LVL_W-1:0]   cfgLevel,
  input  logic [SLOT_W-1:0]  cfgSlot,
  input  logic [2:0]         cfgCode,
  input  logic [DEPTH_W-1:0] depthVal,
  input  logic [LVL_W-1:0]   curLevel,
  output logic               levelHit,
  output logic               lastLevel
);

  logic [2:0]         codeMem [MAX_LEVELS][SLOTS];
  logic [DEPTH_W-1:0] depthReg;
  logic [SLOTS-1:0]   nowSample;
  logic [SLOTS-1:0]   prevSample;
  logic               histValid;
  logic [SLOTS-1:0]   slotOk;

  assign nowSample = {extTrigIn, probe};

  // one register per level and slot; out-of-range indices select nothing
  for (genvar lv = 0; lv < MAX_LEVELS; lv++) begin : gLevel
    for (genvar sl = 0; sl < SLOTS; sl++) begin : gSlot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          codeMem[lv][sl] <= CodeAny;
        end else if (strobe.codeWrite && cfgLevel == LVL_W'(lv)
                     && cfgSlot == SLOT_W'(sl)) begin
          codeMem[lv][sl] <= cfgCode;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthReg <= DEPTH_W'(1);
    end else if (strobe.depthWrite && depthVal >= DEPTH_W'(1)
                 && depthVal <= DEPTH_W'(MAX_LEVELS)) begin
      depthReg <= depthVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      histValid  <= 1'b0;
    end else begin
      prevSample <= nowSample;
      histValid  <= ~strobe.restart;
    end
  end

  for (genvar sl = 0; sl < SLOTS; sl++) begin : gEval
    assign slotOk[sl] = condOk(codeMem[curLevel][sl], nowSample[sl],
                               prevSample[sl], histValid);
  end

  assign levelHit  = &slotOk;
  assign lastLevel = (DEPTH_W'(curLevel) + DEPTH_W'(1)) == depthReg;

endmodule

// File: rtl/trigSeqCtrl.sv
module trigSeqCtrl
  import trigSeqPkg::*;
#(
  parameter int MAX_LEVELS = 10,
  localparam int LVL_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             disarm,
  input  logic             cfgWe,
  input  logic             depthWe,
  input  logic             levelHit,
  input  logic             lastLevel,
  output dpStrobeT         strobe,
  output logic [LVL_W-1:0] curLevel,
  output logic             trigPulse,
  output logic             trigOut
);

  seqStateT state;

  always_comb begin
    strobe.codeWrite  = cfgWe && (state == StIdle);
    strobe.depthWrite = depthWe && (state == StIdle);
    strobe.restart    = arm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= StIdle;
      curLevel  <= '0;
      trigPulse <= 1'b0;
      trigOut   <= 1'b0;
    end else if (disarm) begin
      state     <= StIdle;
      curLevel  <= '0;
      trigPulse <= 1'b0;
      trigOut   <= 1'b0;
    end else if (arm) begin
      state     <= StHunt;
      curLevel  <= '0;
      trigPulse <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      trigPulse <= 1'b0;
      if (state == StHunt && levelHit) begin
        if (lastLevel) begin
          state     <= StDone;
          trigPulse <= 1'b1;
          trigOut   <= 1'b1;
        end else begin
          curLevel <= curLevel + LVL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/trigSeq.sv
module trigSeq
  import trigSeqPkg::*;
#(
  parameter int NUM_SIG    = 8,
  parameter int MAX_LEVELS = 10,
  localparam int LVL_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1,
  localparam int SLOT_W    = $clog2(NUM_SIG + 1),
  localparam int DEPTH_W   = $clog2(MAX_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SIG-1:0] probe,
  input  logic               extTrigIn,
  input  logic               cfgWe,
  input  logic [LVL_W-1:0]   cfgLevel,
  input  logic [SLOT_W-1:0]  cfgSlot,
  input  logic [2:0]         cfgCode,
  input  logic               depthWe,
  input  logic [DEPTH_W-1:0] depthVal,
  input  logic               arm,
  input  logic               disarm,
  output logic               trigPulse,
  output logic               trigOut
);

  dpStrobeT         strobe;
  logic [LVL_W-1:0] curLevel;
  logic             levelHit;
  logic             lastLevel;

  trigSeqCtrl #(.MAX_LEVELS(MAX_LEVELS)) uCtrl (
    .clk(clk), .rstN(rstN), .arm(arm), .disarm(disarm),
    .cfgWe(cfgWe), .depthWe(depthWe),
    .levelHit(levelHit), .lastLevel(lastLevel),
    .strobe(strobe), .curLevel(curLevel),
    .trigPulse(trigPulse), .trigOut(trigOut)
  );

  trigSeqData #(.NUM_SIG(NUM_SIG), .MAX_LEVELS(MAX_LEVELS)) uData (
    .clk(clk), .rstN(rstN), .probe(probe), .extTrigIn(extTrigIn),
    .strobe(strobe), .cfgLevel(cfgLevel), .cfgSlot(cfgSlot),
    .cfgCode(cfgCode), .depthVal(depthVal), .curLevel(curLevel),
    .levelHit(levelHit), .lastLevel(lastLevel)
  );

endmodule

// File: rtl/trigSeqChecker.sv
module trigSeqChecker (
  input logic clk,
  input logic rstN,
  input logic arm,
  input logic disarm,
  input logic trigPulse,
  input logic trigOut
);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  assert_out_with_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> trigOut);

  assert_out_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> trigPulse);

  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && !arm && !disarm) |=> (trigOut && !trigPulse));

  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!trigOut && !trigPulse));

  assert_disarm_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    disarm |=> (!trigOut && !trigPulse));

endmodule

bind trigSeq trigSeqChecker uCheck (
  .clk(clk), .rstN(rstN), .arm(arm), .disarm(disarm),
  .trigPulse(trigPulse), .trigOut(trigOut)
);

// File: tb/trigSeq_test.sv
module trigSeq_test;
  localparam int NS = 4;
  localparam int ML = 10;
  localparam int LW = 4;
  localparam int SW = 3;
  localparam int DW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [NS-1:0] probe;
  logic extIn;
  logic cfgWe, peerWe, depthWe, arm, disarm;
  logic [LW-1:0] cfgLevel;
  logic [SW-1:0] cfgSlot;
  logic [2:0] cfgCode;
  logic [DW-1:0] depthVal;
  logic trigPulse, trigOut, peerPulse, peerOut;

  trigSeq #(.NUM_SIG(NS), .MAX_LEVELS(ML)) uut (
    .clk(clk), .rstN(rstN), .probe(probe), .extTrigIn(extIn),
    .cfgWe(cfgWe), .cfgLevel(cfgLevel), .cfgSlot(cfgSlot), .cfgCode(cfgCode),
    .depthWe(depthWe), .depthVal(depthVal), .arm(arm), .disarm(disarm),
    .trigPulse(trigPulse), .trigOut(trigOut)
  );

  trigSeq #(.NUM_SIG(NS), .MAX_LEVELS(ML)) peer (
    .clk(clk), .rstN(rstN), .probe(probe), .extTrigIn(trigOut),
    .cfgWe(peerWe), .cfgLevel(cfgLevel), .cfgSlot(cfgSlot), .cfgCode(cfgCode),
    .depthWe(1'b0), .depthVal(depthVal), .arm(arm), .disarm(disarm),
    .trigPulse(peerPulse), .trigOut(peerOut)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit chainOn = 1'b0;

  // behavioural reference
  int mState, mLevel, mDepth;
  int mCode [ML][NS+1];
  bit mPulse, mOut, mHv, mPulsePrev;
  logic [NS:0] mPrev;

  function automatic bit condTrue(int c, bit cur, bit prv, bit hv);
    case (c)
      1: return !cur;
      2: return cur;
      3: return hv && cur && !prv;
      4: return hv && !cur && prv;
      5: return hv && (cur != prv);
      default: return 1'b1;
    endcase
  endfunction

  task automatic modelStep();
    logic [NS:0] now;
    bit hit;
    bit idle;
    now = {extIn, probe};
    mPulsePrev = mPulse;
    if (!rstN) begin
      mState = 0; mLevel = 0; mDepth = 1; mPulse = 0; mOut = 0; mHv = 0;
      mPrev = '0;
      foreach (mCode[l, s]) mCode[l][s] = 0;
      return;
    end
    hit = 1'b1;
    for (int s = 0; s <= NS; s++)
      hit &= condTrue(mCode[mLevel][s], now[s], mPrev[s], mHv);
    idle = (mState == 0);
    if (idle && cfgWe && int'(cfgLevel) < ML && int'(cfgSlot) <= NS)
      mCode[cfgLevel][cfgSlot] = int'(cfgCode);
    if (idle && depthWe && depthVal >= 1 && int'(depthVal) <= ML)
      mDepth = int'(depthVal);
    if (disarm) begin
      mState = 0; mLevel = 0; mPulse = 0; mOut = 0;
    end else if (arm) begin
      mState = 1; mLevel = 0; mPulse = 0; mOut = 0;
    end else begin
      mPulse = 0;
      if (mState == 1 && hit) begin
        if (mLevel == mDepth - 1) begin
          mState = 2; mPulse = 1; mOut = 1;
        end else begin
          mLevel++;
        end
      end
    end
    mHv = !arm;
    mPrev = now;
  endtask

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk(trigPulse == mPulse, "trigPulse vs model", int'(trigPulse), int'(mPulse));
    chk(trigOut == mOut, "trigOut vs model", int'(trigOut), int'(mOut));
    if (chainOn)
      chk(peerPulse == mPulsePrev, "peer pulse follows trigOut",
          int'(peerPulse), int'(mPulsePrev));
  endtask

  task automatic wrCode(int l, int s, int c);
    cfgWe = 1; cfgLevel = LW'(l); cfgSlot = SW'(s); cfgCode = 3'(c);
    tick();
    cfgWe = 0;
  endtask

  task automatic wrDepth(int d);
    depthWe = 1; depthVal = DW'(d);
    tick();
    depthWe = 0;
  endtask

  task automatic doArm();
    arm = 1; tick(); arm = 0;
  endtask

  task automatic doDisarm();
    disarm = 1; tick(); disarm = 0;
  endtask

  task automatic setProbe(logic [NS-1:0] v);
    probe = v; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; probe = '0; extIn = 0; cfgWe = 0; peerWe = 0; depthWe = 0;
    arm = 0; disarm = 0; cfgLevel = '0; cfgSlot = '0; cfgCode = '0; depthVal = '0;
    tick(); tick();
    rstN = 1;
    tick();
    // R1: reset state and defaults (depth 1, all don't care)
    tag = "R1";
    chk(trigPulse == 0 && trigOut == 0, "outputs after reset", int'(trigOut), 0);
    doArm();
    tick();
    chk(trigPulse == 1, "default level fires at once", int'(trigPulse), 1);
    tick();
    chk(trigPulse == 0 && trigOut == 1, "pulse one cycle, out held", int'(trigOut), 1);

    // R2 R4 R5: three-level sequence
    tag = "R4";
    doDisarm();
    wrCode(0, 0, 2);
    wrCode(1, 1, 1);
    wrCode(1, 2, 2);
    wrCode(2, 3, 4);
    wrDepth(3);
    probe = '0;
    doArm();
    setProbe(4'b0001);
    setProbe(4'b0000);
    chk(trigOut == 0, "level two needs both slots", int'(trigOut), 0);
    setProbe(4'b0100);
    setProbe(4'b1000);
    tag = "R5";
    setProbe(4'b0000);
    chk(trigPulse == 1, "third level falling edge completes", int'(trigPulse), 1);

    // R7: no retrigger, re-arm restarts at level one
    tag = "R7";
    setProbe(4'b0001); setProbe(4'b0100); setProbe(4'b1000); setProbe(4'b0000);
    chk(trigPulse == 0 && trigOut == 1, "matches ignored after trigger", int'(trigPulse), 0);
    doArm();
    setProbe(4'b0001);
    doArm();
    setProbe(4'b0100);
    setProbe(4'b1000);
    setProbe(4'b0000);
    chk(trigOut == 0, "re-arm went back to level one", int'(trigOut), 0);

    // R3: first cycle after arm cannot see an edge
    tag = "R3";
    doDisarm();
    wrCode(0, 0, 3);
    wrDepth(1);
    probe = '0;
    doArm();
    setProbe(4'b0001);
    setProbe(4'b0001);
    chk(trigOut == 0, "edge in first armed cycle ignored", int'(trigOut), 0);
    setProbe(4'b0000);
    setProbe(4'b0001);
    chk(trigPulse == 1, "later rising edge fires", int'(trigPulse), 1);

    // R2: either edge and codes 6, 7 as don't care
    tag = "R2";
    doDisarm();
    wrCode(0, 0, 5);
    wrCode(0, 1, 6);
    wrCode(0, 2, 7);
    probe = 4'b0001;
    doArm();
    setProbe(4'b0001);
    setProbe(4'b0000);
    chk(trigPulse == 1, "falling edge meets either-edge code", int'(trigPulse), 1);

    // R8: writes while armed and out-of-range writes ignored
    tag = "R8";
    doDisarm();
    wrCode(0, 0, 2);
    probe = '0;
    doArm();
    wrCode(0, 0, 1);
    wrDepth(2);
    setProbe(4'b0001);
    chk(trigPulse == 1, "write while armed ignored", int'(trigPulse), 1);
    doDisarm();
    wrCode(12, 0, 1);
    wrCode(0, 7, 1);
    tag = "R5";
    wrDepth(0);
    wrDepth(11);
    probe = 4'b0001;
    doArm();
    tick();
    chk(trigPulse == 1, "bad depth and index writes ignored", int'(trigPulse), 1);

    // R9: disarm from hunting, disarm beats arm
    tag = "R9";
    doDisarm();
    probe = '0;
    doArm();
    disarm = 1; arm = 1; tick(); disarm = 0; arm = 0;
    setProbe(4'b0001);
    chk(trigPulse == 0 && trigOut == 0, "disarm wins over arm", int'(trigOut), 0);
    doArm();
    setProbe(4'b0001);
    doDisarm();
    chk(trigOut == 0, "disarm clears trigOut", int'(trigOut), 0);

    // R10: external slot and chained instance
    tag = "R10";
    wrCode(0, 0, 0);
    wrCode(0, NS, 2);
    extIn = 0;
    doArm();
    tick();
    chk(trigOut == 0, "external low blocks", int'(trigOut), 0);
    extIn = 1; tick(); tick();
    chk(trigOut == 1, "external high fires", int'(trigOut), 1);
    doDisarm();
    extIn = 0;
    peerWe = 1; cfgLevel = '0; cfgSlot = SW'(NS); cfgCode = 3'd3; tick(); peerWe = 0;
    doArm();
    chainOn = 1;
    tick(); tick();
    extIn = 1;
    repeat (4) tick();
    chk(peerOut == 1, "peer triggered from trigOut", int'(peerOut), 1);
    chainOn = 0;

    // R6: random traffic checked cycle by cycle
    tag = "R6";
    doDisarm();
    for (int i = 0; i < 3000; i++) begin
      probe    = NS'($urandom);
      extIn    = 1'($urandom);
      arm      = ($urandom % 100) < 6;
      disarm   = ($urandom % 100) < 3;
      cfgWe    = ($urandom % 100) < 30;
      cfgLevel = LW'($urandom);
      cfgSlot  = SW'($urandom);
      cfgCode  = 3'($urandom);
      depthWe  = ($urandom % 100) < 10;
      depthVal = DW'($urandom % 4);
      tick();
    end
    arm = 0; disarm = 0; cfgWe = 0; depthWe = 0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule